// File: doc/BRIEF.md
# Single-Cycle Datapath Control Decoder

This block is the control decoder of a single-cycle sequential processor. Each cycle it takes the fetched instruction fields (opcode, function code, two register identifiers), the word values already gathered for that instruction (two register operands, the constant word, the fall-through address, the ALU result and the value read from data memory) and the branch flag. From these it produces every steering decision the datapath needs. It gives the register-file read and write identifiers, the two ALU operands, the ALU function and a condition-code load enable. It also gives the data-memory address, the read and write strobes, the write data and the next program counter.

The register file, ALU and memories sit outside the block. Every selection is driven by a membership test on the opcode: implicit stack-pointer operands, the plus and minus stack-step constants, and the choice of next PC among the fall-through address, the constant and the loaded word. An immediate-add instruction is included when the parameter `EN_IADD` is set, which is the default. All outputs are registered, so the decision for the inputs present at one rising edge shows at the outputs until the next edge.

Top module: `seqdec_top`

## Requirements
- R1: While `rst` is high at a rising edge, every register identifier output becomes 0xF, `mem_rd`, `mem_wr` and `set_cc` become 0, and every word output and `alu_fn` become 0.
- R2: Opcode values are 0 halt, 1 nop, 2 reg-to-reg move, 3 immediate move, 4 store, 5 load, 6 ALU op, 7 jump, 8 call, 9 return, 0xA push, 0xB pop, 0xC immediate add. Outputs show the decision for the inputs sampled at the previous rising edge and stay unchanged between edges.
- R3: `src_a` is `ra` for move, store, ALU op and push; it is the stack pointer (id 4) for pop and return; otherwise 0xF.
- R4: `src_b` is `rb` for ALU op, store, load and immediate add; it is 4 for push, pop, call and return; otherwise 0xF.
- R5: `dst_e` is `rb` for move, immediate move, ALU op and immediate add, and 4 for push, pop, call and return. `dst_m` is `ra` for load and pop. Both are 0xF in every other case, so a pop names two write targets.
- R6: `alu_a` is `val_a` for move and ALU op. It is `val_c` for immediate move, store, load and immediate add. It is minus 4 (0xFFFFFFFC) for call and push, plus 4 for return and pop, and 0 otherwise.
- R7: `alu_b` is `val_b` for store, load, ALU op, call, return, push, pop and immediate add, and 0 otherwise. `alu_fn` equals `ifun` for ALU op only and is 0 (add) for every other opcode.
- R8: `set_cc` is 1 exactly for ALU op and immediate add.
- R9: `mem_addr` is `val_e` for store, push, call and load, and `val_a` for pop and return, else 0. `mem_rd` is 1 for load, pop and return. `mem_wr` is 1 for store, push and call. `mem_wdata` is `val_p` for call and `val_a` otherwise.
- R10: `next_pc` is `val_c` for call and for a jump with `bch` high, `val_m` for return, and `val_p` otherwise, including a jump with `bch` low and any non-jump with `bch` high.
- R11: Immediate add reads `rb`, adds `val_c` to it, writes the result back to `rb` and loads the condition codes; `ifun` has no effect on it.
- R12: Halt, nop and the unassigned opcodes 0xD to 0xF access no register and no memory, set no condition codes and select add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| icode | input | 4 | Opcode |
| ifun | input | 4 | Function code |
| ra | input | REG_W | First register identifier |
| rb | input | REG_W | Second register identifier |
| val_a | input | WORD_W | First register operand |
| val_b | input | WORD_W | Second register operand |
| val_c | input | WORD_W | Constant word |
| val_e | input | WORD_W | ALU result |
| val_p | input | WORD_W | Fall-through address |
| val_m | input | WORD_W | Word read from data memory |
| bch | input | 1 | Branch condition flag |
| src_a | output | REG_W | Read port A identifier |
| src_b | output | REG_W | Read port B identifier |
| dst_e | output | REG_W | Write port E identifier |
| dst_m | output | REG_W | Write port M identifier |
| alu_a | output | WORD_W | ALU operand A |
| alu_b | output | WORD_W | ALU operand B |
| alu_fn | output | 4 | ALU function |
| set_cc | output | 1 | Condition-code load enable |
| mem_addr | output | WORD_W | Data-memory address |
| mem_rd | output | 1 | Data-memory read strobe |
| mem_wr | output | 1 | Data-memory write strobe |
| mem_wdata | output | WORD_W | Data-memory write data |
| next_pc | output | WORD_W | Next program counter |

## Verification
The block holds no state beyond its output register, so a wrong decision cannot linger or hide. A misclassified opcode appears one cycle after the instruction is presented, as a wrong register id, a stray strobe or a wrong PC source. The bench therefore presents each opcode with distinct word values on every input. A swapped mux leg then shows as a recognisably wrong value in the same checked cycle, and an output pipeline stage that is missing or doubled shows as a value that is a cycle early or late.

// File: rtl/seqdec_pkg.sv
package seqdec_pkg;

  typedef enum logic [3:0] {
    OP_HALT  = 4'h0,
    OP_NOP   = 4'h1,
    OP_RRMOV = 4'h2,
    OP_IRMOV = 4'h3,
    OP_STORE = 4'h4,
    OP_LOAD  = 4'h5,
    OP_ALU   = 4'h6,
    OP_JUMP  = 4'h7,
    OP_CALL  = 4'h8,
    OP_RET   = 4'h9,
    OP_PUSH  = 4'hA,
    OP_POP   = 4'hB,
    OP_IADD  = 4'hC
  } opcode_e;

  localparam logic [3:0] FN_ADD = 4'h0;

  // One flag per recognised instruction class.
  typedef struct packed {
    logic rrmov;
    logic irmov;
    logic store;
    logic load;
    logic alu;
    logic jump;
    logic call;
    logic ret;
    logic push;
    logic pop;
    logic iadd;
  } op_flags_t;

endpackage

// File: rtl/seqdec_classify.sv
module seqdec_classify
  import seqdec_pkg::*;
#(
  parameter bit EN_IADD = 1'b1
) (
  input  logic [3:0] icode,
  output op_flags_t  flags
);

  logic iadd_hit;

  generate
    if (EN_IADD) begin : g_iadd
      assign iadd_hit = (icode == 4'(OP_IADD));
    end else begin : g_no_iadd
      assign iadd_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    flags       = '0;
    flags.rrmov = (icode == 4'(OP_RRMOV));
    flags.irmov = (icode == 4'(OP_IRMOV));
    flags.store = (icode == 4'(OP_STORE));
    flags.load  = (icode == 4'(OP_LOAD));
    flags.alu   = (icode == 4'(OP_ALU));
    flags.jump  = (icode == 4'(OP_JUMP));
    flags.call  = (icode == 4'(OP_CALL));
    flags.ret   = (icode == 4'(OP_RET));
    flags.push  = (icode == 4'(OP_PUSH));
    flags.pop   = (icode == 4'(OP_POP));
    flags.iadd  = iadd_hit;
  end

endmodule

// File: rtl/seqdec_regsel.sv
module seqdec_regsel
  import seqdec_pkg::*;
#(
  parameter int REG_W   = 4,
  parameter int SP_ID   = 4,
  parameter int NONE_ID = 15
) (
  input  op_flags_t        flags,
  input  logic [REG_W-1:0] ra,
  input  logic [REG_W-1:0] rb,
  output logic [REG_W-1:0] src_a,
  output logic [REG_W-1:0] src_b,
  output logic [REG_W-1:0] dst_e,
  output logic [REG_W-1:0] dst_m
);

  localparam logic [REG_W-1:0] SP   = REG_W'(SP_ID);
  localparam logic [REG_W-1:0] NONE = REG_W'(NONE_ID);

  logic stack_op;
  logic a_from_ra, a_from_sp;
  logic b_from_rb;
  logic e_to_rb;
  logic m_to_ra;

  assign stack_op  = flags.push | flags.pop | flags.call | flags.ret;
  assign a_from_ra = flags.rrmov | flags.store | flags.alu | flags.push;
  assign a_from_sp = flags.pop | flags.ret;
  assign b_from_rb = flags.alu | flags.store | flags.load | flags.iadd;
  assign e_to_rb   = flags.rrmov | flags.irmov | flags.alu | flags.iadd;
  assign m_to_ra   = flags.load | flags.pop;

  always_comb begin
    src_a = NONE;
    if (a_from_ra)      src_a = ra;
    else if (a_from_sp) src_a = SP;

    src_b = NONE;
    if (b_from_rb)     src_b = rb;
    else if (stack_op) src_b = SP;

    dst_e = NONE;
    if (e_to_rb)       dst_e = rb;
    else if (stack_op) dst_e = SP;

    dst_m = m_to_ra ? ra : NONE;
  end

endmodule

// File: rtl/seqdec_alusel.sv
module seqdec_alusel
  import seqdec_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int STACK_STEP = 4
) (
  input  op_flags_t         flags,
  input  logic [3:0]        ifun,
  input  logic [WORD_W-1:0] val_a,
  input  logic [WORD_W-1:0] val_b,
  input  logic [WORD_W-1:0] val_c,
  output logic [WORD_W-1:0] alu_a,
  output logic [WORD_W-1:0] alu_b,
  output logic [3:0]        alu_fn,
  output logic              set_cc
);

  localparam logic [WORD_W-1:0] STEP_UP   = WORD_W'(STACK_STEP);
  localparam logic [WORD_W-1:0] STEP_DOWN = ~STEP_UP + WORD_W'(1);

  logic a_reg, a_const, a_down, a_up, b_reg;

  assign a_reg   = flags.rrmov | flags.alu;
  assign a_const = flags.irmov | flags.store | flags.load | flags.iadd;
  assign a_down  = flags.call | flags.push;
  assign a_up    = flags.ret | flags.pop;
  assign b_reg   = flags.store | flags.load | flags.alu | flags.call |
                   flags.ret | flags.push | flags.pop | flags.iadd;

  always_comb begin
    alu_a = '0;
    if (a_reg)        alu_a = val_a;
    else if (a_const) alu_a = val_c;
    else if (a_down)  alu_a = STEP_DOWN;
    else if (a_up)    alu_a = STEP_UP;

    alu_b  = b_reg ? val_b : '0;
    alu_fn = flags.alu ? ifun : FN_ADD;
    set_cc = flags.alu | flags.iadd;
  end

endmodule

// File: rtl/seqdec_memsel.sv
module seqdec_memsel
  import seqdec_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  op_flags_t         flags,
  input  logic              bch,
  input  logic [WORD_W-1:0] val_a,
  input  logic [WORD_W-1:0] val_c,
  input  logic [WORD_W-1:0] val_e,
  input  logic [WORD_W-1:0] val_p,
  input  logic [WORD_W-1:0] val_m,
  output logic [WORD_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [WORD_W-1:0] next_pc
);

  logic addr_e, addr_a, to_target;

  assign addr_e    = flags.store | flags.push | flags.call | flags.load;
  assign addr_a    = flags.pop | flags.ret;
  assign to_target = flags.call | (flags.jump & bch);

  always_comb begin
    mem_addr = '0;
    if (addr_e)      mem_addr = val_e;
    else if (addr_a) mem_addr = val_a;

    mem_rd    = flags.load | flags.pop | flags.ret;
    mem_wr    = flags.store | flags.push | flags.call;
    mem_wdata = flags.call ? val_p : val_a;

    next_pc = val_p;
    if (to_target)      next_pc = val_c;
    else if (flags.ret) next_pc = val_m;
  end

endmodule

// File: rtl/seqdec_top.sv
module seqdec_top
  import seqdec_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int REG_W      = 4,
  parameter int SP_ID      = 4,
  parameter int NONE_ID    = 15,
  parameter int STACK_STEP = 4,
  parameter bit EN_IADD    = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        icode,
  input  logic [3:0]        ifun,
  input  logic [REG_W-1:0]  ra,
  input  logic [REG_W-1:0]  rb,
  input  logic [WORD_W-1:0] val_a,
  input  logic [WORD_W-1:0] val_b,
  input  logic [WORD_W-1:0] val_c,
  input  logic [WORD_W-1:0] val_e,
  input  logic [WORD_W-1:0] val_p,
  input  logic [WORD_W-1:0] val_m,
  input  logic              bch,
  output logic [REG_W-1:0]  src_a,
  output logic [REG_W-1:0]  src_b,
  output logic [REG_W-1:0]  dst_e,
  output logic [REG_W-1:0]  dst_m,
  output logic [WORD_W-1:0] alu_a,
  output logic [WORD_W-1:0] alu_b,
  output logic [3:0]        alu_fn,
  output logic              set_cc,
  output logic [WORD_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [WORD_W-1:0] next_pc
);

  localparam logic [REG_W-1:0] NONE = REG_W'(NONE_ID);

  op_flags_t         flags;
  logic [REG_W-1:0]  n_src_a, n_src_b, n_dst_e, n_dst_m;
  logic [WORD_W-1:0] n_alu_a, n_alu_b, n_mem_addr, n_mem_wdata, n_next_pc;
  logic [3:0]        n_alu_fn;
  logic              n_set_cc, n_mem_rd, n_mem_wr;

  seqdec_classify #(.EN_IADD(EN_IADD)) u_classify (
    .icode (icode),
    .flags (flags)
  );

  seqdec_regsel #(.REG_W(REG_W), .SP_ID(SP_ID), .NONE_ID(NONE_ID)) u_regsel (
    .flags (flags),
    .ra    (ra),
    .rb    (rb),
    .src_a (n_src_a),
    .src_b (n_src_b),
    .dst_e (n_dst_e),
    .dst_m (n_dst_m)
  );

  seqdec_alusel #(.WORD_W(WORD_W), .STACK_STEP(STACK_STEP)) u_alusel (
    .flags  (flags),
    .ifun   (ifun),
    .val_a  (val_a),
    .val_b  (val_b),
    .val_c  (val_c),
    .alu_a  (n_alu_a),
    .alu_b  (n_alu_b),
    .alu_fn (n_alu_fn),
    .set_cc (n_set_cc)
  );

  seqdec_memsel #(.WORD_W(WORD_W)) u_memsel (
    .flags     (flags),
    .bch       (bch),
    .val_a     (val_a),
    .val_c     (val_c),
    .val_e     (val_e),
    .val_p     (val_p),
    .val_m     (val_m),
    .mem_addr  (n_mem_addr),
    .mem_rd    (n_mem_rd),
    .mem_wr    (n_mem_wr),
    .mem_wdata (n_mem_wdata),
    .next_pc   (n_next_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_a     <= NONE;
      src_b     <= NONE;
      dst_e     <= NONE;
      dst_m     <= NONE;
      alu_a     <= '0;
      alu_b     <= '0;
      alu_fn    <= FN_ADD;
      set_cc    <= 1'b0;
      mem_addr  <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_wdata <= '0;
      next_pc   <= '0;
    end else begin
      src_a     <= n_src_a;
      src_b     <= n_src_b;
      dst_e     <= n_dst_e;
      dst_m     <= n_dst_m;
      alu_a     <= n_alu_a;
      alu_b     <= n_alu_b;
      alu_fn    <= n_alu_fn;
      set_cc    <= n_set_cc;
      mem_addr  <= n_mem_addr;
      mem_rd    <= n_mem_rd;
      mem_wr    <= n_mem_wr;
      mem_wdata <= n_mem_wdata;
      next_pc   <= n_next_pc;
    end
  end

endmodule

// File: rtl/seqdec_checker.sv
module seqdec_checker #(
  parameter int WORD_W  = 32,
  parameter int REG_W   = 4,
  parameter int SP_ID   = 4,
  parameter int NONE_ID = 15
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        icode,
  input logic [REG_W-1:0]  ra,
  input logic [WORD_W-1:0] val_a,
  input logic [WORD_W-1:0] val_p,
  input logic [WORD_W-1:0] val_m,
  input logic [REG_W-1:0]  src_a,
  input logic [REG_W-1:0]  dst_e,
  input logic [REG_W-1:0]  dst_m,
  input logic              set_cc,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic [WORD_W-1:0] next_pc
);

  localparam logic [REG_W-1:0] SP   = REG_W'(SP_ID);
  localparam logic [REG_W-1:0] NONE = REG_W'(NONE_ID);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_rd && !mem_wr && !set_cc && src_a == NONE && dst_m == NONE)); // R1

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R9

  AST_RET_TARGET: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(icode) == 4'h9) |-> (next_pc == $past(val_m) && mem_rd)); // R10

  AST_CALL_PUSHES_RETURN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(icode) == 4'h8) |-> (mem_wr && mem_wdata == $past(val_p) && dst_e == SP)); // R9

  AST_POP_TWO_TARGETS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(icode) == 4'hB) |-> (dst_e == SP && dst_m == $past(ra) && src_a == SP)); // R5

  AST_CC_ONLY_ARITH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && set_cc) |-> ($past(icode) == 4'h6 || $past(icode) == 4'hC)); // R8

  AST_STORE_DATA: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(icode) == 4'h4) |-> (mem_wr && mem_wdata == $past(val_a))); // R9

endmodule

bind seqdec_top seqdec_checker #(
  .WORD_W(WORD_W), .REG_W(REG_W), .SP_ID(SP_ID), .NONE_ID(NONE_ID)
) u_chk (
  .clk(clk), .rst(rst), .icode(icode), .ra(ra), .val_a(val_a),
  .val_p(val_p), .val_m(val_m), .src_a(src_a), .dst_e(dst_e),
  .dst_m(dst_m), .set_cc(set_cc), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_wdata(mem_wdata), .next_pc(next_pc)
);

// File: tb/seqdec_top_bench.sv
module seqdec_top_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  icode = 4'h1, ifun = 4'h5, ra = 4'h3, rb = 4'h6;
  logic [31:0] val_a = 32'h0000_1111, val_b = 32'h0000_2000, val_c = 32'h0000_0040;
  logic [31:0] val_e = 32'h0000_2FFC, val_p = 32'h0000_0106, val_m = 32'h0000_05A0;
  logic        bch = 1'b0;

  logic [3:0]  src_a, src_b, dst_e, dst_m, alu_fn;
  logic [31:0] alu_a, alu_b, mem_addr, mem_wdata, next_pc;
  logic        set_cc, mem_rd, mem_wr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  localparam logic [3:0]  NO  = 4'hF;
  localparam logic [3:0]  SP  = 4'h4;
  localparam logic [31:0] DN4 = 32'hFFFF_FFFC;
  localparam logic [31:0] UP4 = 32'h0000_0004;

  always #10 clk = ~clk;

  seqdec_top u_seqdec_top (
    .clk(clk), .rst(rst), .icode(icode), .ifun(ifun), .ra(ra), .rb(rb),
    .val_a(val_a), .val_b(val_b), .val_c(val_c), .val_e(val_e),
    .val_p(val_p), .val_m(val_m), .bch(bch),
    .src_a(src_a), .src_b(src_b), .dst_e(dst_e), .dst_m(dst_m),
    .alu_a(alu_a), .alu_b(alu_b), .alu_fn(alu_fn), .set_cc(set_cc),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .next_pc(next_pc)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Present an instruction at a falling edge; results are stable by the next one.
  task automatic issue(input logic [3:0] op, input logic [3:0] fn, input logic br);
    icode = op; ifun = fn; bch = br;
    @(negedge clk);
  endtask

  task automatic regs(input string req, input logic [3:0] sa, input logic [3:0] sb,
                      input logic [3:0] de, input logic [3:0] dm);
    chk(req, "src_a", 32'(src_a), 32'(sa));
    chk(req, "src_b", 32'(src_b), 32'(sb));
    chk(req, "dst_e", 32'(dst_e), 32'(de));
    chk(req, "dst_m", 32'(dst_m), 32'(dm));
  endtask

  task automatic alu(input string req, input logic [31:0] a, input logic [31:0] b,
                     input logic [3:0] fn, input logic cc);
    chk(req, "alu_a", alu_a, a);
    chk(req, "alu_b", alu_b, b);
    chk(req, "alu_fn", 32'(alu_fn), 32'(fn));
    chk(req, "set_cc", 32'(set_cc), 32'(cc));
  endtask

  task automatic mem(input string req, input logic [31:0] ad, input logic rd,
                     input logic wr, input logic [31:0] wd);
    chk(req, "mem_addr", mem_addr, ad);
    chk(req, "mem_rd", 32'(mem_rd), 32'(rd));
    chk(req, "mem_wr", 32'(mem_wr), 32'(wr));
    chk(req, "mem_wdata", mem_wdata, wd);
  endtask

  task automatic t_reset;
    regs("R1", NO, NO, NO, NO);
    alu("R1", 32'h0, 32'h0, 4'h0, 1'b0);
    mem("R1", 32'h0, 1'b0, 1'b0, 32'h0);
    chk("R1", "next_pc", next_pc, 32'h0);
  endtask

  task automatic t_moves;
    issue(4'h2, 4'h5, 1'b0);
    regs("R3_R5 rrmov", 4'h3, NO, 4'h6, NO);
    alu("R6_R7 rrmov", val_a, 32'h0, 4'h0, 1'b0);
    mem("R9 rrmov", 32'h0, 1'b0, 1'b0, val_a);
    chk("R10 rrmov", "next_pc", next_pc, val_p);
    issue(4'h3, 4'h5, 1'b0);
    regs("R4_R5 irmov", NO, NO, 4'h6, NO);
    alu("R6 irmov", val_c, 32'h0, 4'h0, 1'b0);
  endtask

  task automatic t_memops;
    issue(4'h4, 4'h5, 1'b0);
    regs("R3_R4 store", 4'h3, 4'h6, NO, NO);
    alu("R6_R7 store", val_c, val_b, 4'h0, 1'b0);
    mem("R9 store", val_e, 1'b0, 1'b1, val_a);
    issue(4'h5, 4'h5, 1'b0);
    regs("R5 load", NO, 4'h6, NO, 4'h3);
    alu("R6 load", val_c, val_b, 4'h0, 1'b0);
    mem("R9 load", val_e, 1'b1, 1'b0, val_a);
  endtask

  task automatic t_aluop;
    issue(4'h6, 4'h2, 1'b0);
    regs("R3_R4 aluop", 4'h3, 4'h6, 4'h6, NO);
    alu("R7_R8 aluop", val_a, val_b, 4'h2, 1'b1);
    mem("R9 aluop", 32'h0, 1'b0, 1'b0, val_a);
  endtask

  task automatic t_jumps;
    issue(4'h7, 4'h3, 1'b1);
    chk("R10 jump taken", "next_pc", next_pc, val_c);
    regs("R12 jump", NO, NO, NO, NO);
    issue(4'h7, 4'h3, 1'b0);
    chk("R10 jump not taken", "next_pc", next_pc, val_p);
    issue(4'h1, 4'h0, 1'b1);
    chk("R10 nop with bch", "next_pc", next_pc, val_p);
  endtask

  task automatic t_stack;
    issue(4'h8, 4'h5, 1'b0);
    regs("R4_R5 call", NO, SP, SP, NO);
    alu("R6 call", DN4, val_b, 4'h0, 1'b0);
    mem("R9 call", val_e, 1'b0, 1'b1, val_p);
    chk("R10 call", "next_pc", next_pc, val_c);
    issue(4'h9, 4'h5, 1'b0);
    regs("R3_R5 ret", SP, SP, SP, NO);
    alu("R6 ret", UP4, val_b, 4'h0, 1'b0);
    mem("R9 ret", val_a, 1'b1, 1'b0, val_a);
    chk("R10 ret", "next_pc", next_pc, val_m);
    issue(4'hA, 4'h5, 1'b0);
    regs("R3_R5 push", 4'h3, SP, SP, NO);
    alu("R6 push", DN4, val_b, 4'h0, 1'b0);
    mem("R9 push", val_e, 1'b0, 1'b1, val_a);
    issue(4'hB, 4'h5, 1'b0);
    regs("R5 pop", SP, SP, SP, 4'h3);
    alu("R6 pop", UP4, val_b, 4'h0, 1'b0);
    mem("R9 pop", val_a, 1'b1, 1'b0, val_a);
  endtask

  task automatic t_iadd;
    issue(4'hC, 4'h3, 1'b0);
    regs("R11 iadd", NO, 4'h6, 4'h6, NO);
    alu("R11 iadd", val_c, val_b, 4'h0, 1'b1);
    mem("R11 iadd", 32'h0, 1'b0, 1'b0, val_a);
  endtask

  task automatic t_idle_codes;
    logic [3:0] codes [5] = '{4'h0, 4'h1, 4'hD, 4'hE, 4'hF};
    for (int i = 0; i < 5; i++) begin
      issue(codes[i], 4'h5, 1'b0);
      regs("R12 idle", NO, NO, NO, NO);
      alu("R12 idle", 32'h0, 32'h0, 4'h0, 1'b0);
      mem("R12 idle", 32'h0, 1'b0, 1'b0, val_a);
      chk("R12 idle", "next_pc", next_pc, val_p);
    end
  endtask

  task automatic t_latency;
    issue(4'h2, 4'h5, 1'b0);
    icode = 4'h9;
    #5;
    chk("R2 hold before edge", "next_pc", next_pc, val_p);
    chk("R2 hold before edge", "mem_rd", 32'(mem_rd), 32'h0);
    @(negedge clk);
    chk("R2 after edge", "next_pc", next_pc, val_m);
    val_m = 32'h0000_0A5C;
    @(negedge clk);
    chk("R2 tracks new value", "next_pc", next_pc, 32'h0000_0A5C);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_moves();
    t_memops();
    t_aluop();
    t_jumps();
    t_stack();
    t_iadd();
    t_idle_codes();
    t_latency();
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

endmodule